// File: doc/BRIEF.md
# Touch ADC Serial Command Sequencer

This block is the host-side serial master for a resistive touch-panel converter. A client presents a conversion request: an input channel, a resolution choice, a reference choice and two power-control bits. The block packs these into an eight-bit command word behind a leading start marker. It then drives chip select, the serial clock and the serial data line through a fixed frame of 24 clock periods, and collects the converted sample from the returning data line.

The client sees a simple start/busy/done handshake. A `start` pulse is accepted only while the block is idle. `done` pulses for one cycle when the 12-bit right-aligned `result` is ready, together with the channel code it was taken from. The serial clock rate comes from a divider set per frame. A scan mode overrides the requested channel and reference choice, so that successive frames alternate between the X and Y position inputs in differential mode.

Top module: `tadc_seq`

## Requirements
- R1: Each accepted request produces exactly 24 rising edges of `dclk`. `csN` stays low from before the first rising edge until after the last falling edge. `dclk` is low whenever `csN` is high.
- R2: The command word is sent most significant bit first and sampled by the converter on the first 8 rising edges. Its bit 7 is the start marker and is always 1. Bits 6:4 carry the channel code, bit 3 carries `mode8`, bit 2 carries `singleEnded`, and bits 1:0 carry `pwrDown[1:0]`. After the command word, `din` is 0 for the rest of the frame.
- R3: `din` changes only while `dclk` is low. It never changes in the cycle in which `dclk` rises.
- R4: `done` is a single-cycle pulse raised while `busy` is high. `result` and `resultChan` hold the new sample from the `done` cycle until the next `done`.
- R5: With `mode8`=0, `result` holds the 12 bits sampled from `dout` on rising edges 10 through 21, with the first sampled bit as the MSB.
- R6: With `mode8`=1, `result[7:0]` holds the bits sampled on rising edges 10 through 17, first bit as MSB, and `result[11:8]` is 0.
- R7: Between two frames, `csN` stays high for at least 2*(`clkDiv`+1) system cycles, even when `start` is held high throughout.
- R8: When `scanEn`=1, the requested channel is replaced by X (code 3'b101) on the first scanned frame after reset and by Y (code 3'b001) on the next, alternating from then on. The reference bit is forced to 0 (differential). `resultChan` reports the code that was sent.
- R9: A `start` asserted while `busy` is high is ignored. It neither alters the frame in progress nor causes an extra frame.
- R10: Every high phase and every low phase of `dclk` inside a frame lasts `clkDiv`+1 system cycles. The value of `clkDiv` is taken when the request is accepted.
- R11: After reset, `busy`, `done`, `dclk`, `din`, `result` and `resultChan` are 0, and `csN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion frame |
| chan | input | 3 | Requested channel code |
| mode8 | input | 1 | 1 selects 8-bit conversion, 0 selects 12-bit |
| singleEnded | input | 1 | 1 selects single-ended reference, 0 selects differential |
| pwrDown | input | 2 | Power-down / reference-enable bits |
| scanEn | input | 1 | Alternate X and Y channels, differential |
| clkDiv | input | 8 | Serial clock half period minus one, in system cycles |
| dout | input | 1 | Serial data from converter |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle pulse: new result valid |
| result | output | 12 | Right-aligned conversion result |
| resultChan | output | 3 | Channel code the result came from |
| csN | output | 1 | Active-low chip select |
| dclk | output | 1 | Serial clock, idle low |
| din | output | 1 | Serial command data to converter |

## Verification
The bench models the converter. It decodes `din` on rising `dclk` and answers with a 12-bit sample, or the top 8 bits of that sample, after the busy edge. Directed frames use all-zeros, all-ones and single-bit samples in both resolutions, which separates off-by-one capture windows and wrong narrowing. Seeded random requests vary the channel, reference, power bits and divider, so the command packing and half-period timing are checked across settings. Scan runs, back-to-back requests with `start` held high, and a `start` pulse in mid-frame check the channel alternation, the minimum deselect gap and the rejection of requests while busy.

// File: rtl/tadc_pkg.sv
package tadc_pkg;
  localparam int CMD_W = 8;
  localparam logic [2:0] CH_X = 3'b101;
  localparam logic [2:0] CH_Y = 3'b001;

  typedef struct packed {
    logic load;
    logic shiftDin;
    logic capture;
    logic commit;
  } seqStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } seqState_t;
endpackage

// File: rtl/tadc_ctrl.sv
module tadc_ctrl
  import tadc_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FRAME_CLKS = 24,
  parameter int RES_BITS   = 12,
  localparam int CNT_W     = $clog2(FRAME_CLKS + 1),
  localparam int RES_FIRST = CMD_W + 2,
  localparam int RES_LAST  = CMD_W + 1 + RES_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             busy,
  output logic             done,
  output logic             csN,
  output logic             dclk,
  output seqStrb_t         strb
);
  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             gapHalf;
  logic             halfEnd;
  logic             lastClk;

  assign halfEnd = (divCnt == divLat);
  assign nextCnt = bitCnt + CNT_W'(1);
  assign lastClk = (bitCnt == CNT_W'(FRAME_CLKS));
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strb          = '0;
    strb.load     = (state == ST_IDLE) && start;
    strb.shiftDin = (state == ST_HIGH) && halfEnd && !lastClk;
    strb.commit   = (state == ST_HIGH) && halfEnd && lastClk;
    strb.capture  = (state == ST_LOW) && halfEnd &&
                    (nextCnt >= CNT_W'(RES_FIRST)) && (nextCnt <= CNT_W'(RES_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      divLat  <= '0;
      bitCnt  <= '0;
      gapHalf <= 1'b0;
      csN     <= 1'b1;
      dclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= strb.commit;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_LEAD;
            csN    <= 1'b0;
            divCnt <= '0;
            divLat <= clkDiv;
            bitCnt <= '0;
          end
        end
        ST_LEAD: begin
          if (halfEnd) begin
            dclk   <= 1'b1;
            bitCnt <= nextCnt;
            divCnt <= '0;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (halfEnd) begin
            dclk   <= 1'b0;
            divCnt <= '0;
            if (lastClk) begin
              csN     <= 1'b1;
              gapHalf <= 1'b0;
              state   <= ST_GAP;
            end else begin
              state <= ST_LOW;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_LOW: begin
          if (halfEnd) begin
            dclk   <= 1'b1;
            bitCnt <= nextCnt;
            divCnt <= '0;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (halfEnd) begin
            divCnt <= '0;
            if (gapHalf) state <= ST_IDLE;
            else gapHalf <= 1'b1;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: never more clock edges than one frame holds
  a_r1_bitcnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_CLKS));
  // R1: serial clock parked low while deselected
  a_r1_dclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !dclk);
  // R4: done is a single-cycle pulse inside busy
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r4_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R7: gap keeps chip select high
  a_r7_gap_deselect: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> csN);
  // R9: start while busy does not restart the frame
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && state != ST_GAP) |=> busy);
endmodule

// File: rtl/tadc_dp.sv
module tadc_dp
  import tadc_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int NARROW_BITS = 8,
  localparam int PAD        = RES_BITS - NARROW_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrb_t            strb,
  input  logic [2:0]          chan,
  input  logic                mode8,
  input  logic                singleEnded,
  input  logic [1:0]          pwrDown,
  input  logic                scanEn,
  input  logic                dout,
  output logic                din,
  output logic [RES_BITS-1:0] result,
  output logic [2:0]          resultChan
);
  logic [CMD_W-1:0]    cmdSh;
  logic [CMD_W-1:0]    cmdWord;
  logic [RES_BITS-1:0] resSh;
  logic [2:0]          chanSel;
  logic [2:0]          chanLat;
  logic                refSel;
  logic                mode8Lat;
  logic                nextIsY;

  always_comb begin
    chanSel = scanEn ? (nextIsY ? CH_Y : CH_X) : chan;
    refSel  = scanEn ? 1'b0 : singleEnded;
    cmdWord = {1'b1, chanSel, mode8, refSel, pwrDown};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdSh      <= '0;
      resSh      <= '0;
      chanLat    <= '0;
      mode8Lat   <= 1'b0;
      nextIsY    <= 1'b0;
      din        <= 1'b0;
      result     <= '0;
      resultChan <= '0;
    end else begin
      if (strb.load) begin
        cmdSh    <= cmdWord;
        din      <= cmdWord[CMD_W-1];
        resSh    <= '0;
        chanLat  <= chanSel;
        mode8Lat <= mode8;
        if (scanEn) nextIsY <= !nextIsY;
      end
      if (strb.shiftDin) begin
        cmdSh <= {cmdSh[CMD_W-2:0], 1'b0};
        din   <= cmdSh[CMD_W-2];
      end
      if (strb.capture) resSh <= {resSh[RES_BITS-2:0], dout};
      if (strb.commit) begin
        din        <= 1'b0;
        resultChan <= chanLat;
        result     <= mode8Lat ? {{PAD{1'b0}}, resSh[RES_BITS-1:PAD]} : resSh;
      end
    end
  end

  // R2: the first bit placed on din is the start marker
  a_r2_start_marker: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> din);
  // R6: narrow results leave the upper bits clear
  a_r6_narrow_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && mode8Lat) |=> (result[RES_BITS-1:NARROW_BITS] == '0));
  // R4: result only moves on commit
  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(result));
  // R8: scanning always sends a position channel
  a_r8_scan_chan: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && scanEn) |=> (chanLat == CH_X || chanLat == CH_Y));
endmodule

// File: rtl/tadc_seq.sv
module tadc_seq
  import tadc_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          chan,
  input  logic                mode8,
  input  logic                singleEnded,
  input  logic [1:0]          pwrDown,
  input  logic                scanEn,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic                dout,
  output logic                busy,
  output logic                done,
  output logic [RES_BITS-1:0] result,
  output logic [2:0]          resultChan,
  output logic                csN,
  output logic                dclk,
  output logic                din
);
  seqStrb_t strb;

  tadc_ctrl #(.DIV_W(DIV_W), .FRAME_CLKS(24), .RES_BITS(RES_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .clkDiv(clkDiv),
    .busy(busy), .done(done), .csN(csN), .dclk(dclk), .strb(strb)
  );

  tadc_dp #(.RES_BITS(RES_BITS), .NARROW_BITS(8)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chan(chan), .mode8(mode8),
    .singleEnded(singleEnded), .pwrDown(pwrDown), .scanEn(scanEn),
    .dout(dout), .din(din), .result(result), .resultChan(resultChan)
  );

  // R3: data is steady across every rising serial clock edge
  a_r3_din_steady: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dclk) |-> $stable(din));
endmodule

// File: tb/test_tadc_seq.sv
module test_tadc_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  chan = '0;
  logic        mode8 = 1'b0;
  logic        singleEnded = 1'b0;
  logic [1:0]  pwrDown = '0;
  logic        scanEn = 1'b0;
  logic [7:0]  clkDiv = '0;
  logic        dout = 1'b0;
  logic        busy, done, csN, dclk, din;
  logic [11:0] result;
  logic [2:0]  resultChan;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit scanY = 1'b0;

  always #2.5 clk = ~clk;

  tadc_seq i_tadc_seq (
    .clk(clk), .rstN(rstN), .start(start), .chan(chan), .mode8(mode8),
    .singleEnded(singleEnded), .pwrDown(pwrDown), .scanEn(scanEn),
    .clkDiv(clkDiv), .dout(dout), .busy(busy), .done(done),
    .result(result), .resultChan(resultChan), .csN(csN), .dclk(dclk), .din(din)
  );

  // converter model
  logic [11:0] devVal = '0;
  logic [7:0]  cmdRx = '0;
  int          rises = 0;

  always @(posedge dclk or negedge csN) begin
    if (!dclk) rises <= 0;
    else begin
      rises <= rises + 1;
      if (rises < 8) cmdRx <= {cmdRx[6:0], din};
    end
  end

  always @(negedge dclk) begin
    int idx;
    idx = rises - 9;
    if (idx >= 0 && idx < (cmdRx[3] ? 8 : 12)) dout <= devVal[11-idx];
    else dout <= 1'b0;
  end

  // timing monitors
  int highRun = 0, lastGap = 0, hiRun = 0, lastHi = 0, loRun = 0, lastLo = 0;
  logic csPrev = 1'b1;
  always @(posedge clk) begin
    if (csN) highRun <= highRun + 1;
    else begin
      if (csPrev) lastGap <= highRun;
      highRun <= 0;
    end
    csPrev <= csN;
    if (dclk) hiRun <= hiRun + 1;
    else if (hiRun != 0) begin lastHi <= hiRun; hiRun <= 0; end
    if (!dclk && !csN) loRun <= loRun + 1;
    else if (loRun != 0) begin lastLo <= loRun; loRun <= 0; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expCmd(input logic [2:0] c, input logic m,
                                        input logic se, input logic [1:0] pd);
    return {1'b1, c, m, se, pd};
  endfunction

  function automatic logic [11:0] expRes(input logic [11:0] v, input logic m);
    return m ? {4'b0, v[11:4]} : v;
  endfunction

  task automatic frame(input logic [2:0] c, input logic m, input logic se,
                       input logic [1:0] pd, input logic sc, input logic [7:0] dv,
                       input logic [11:0] v, input bit midStart);
    logic [2:0] ec;
    logic       ese;
    devVal = v;
    chan = c; mode8 = m; singleEnded = se; pwrDown = pd; scanEn = sc; clkDiv = dv;
    start = 1'b1;
    while (!(busy && !csN)) @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (20) @(negedge clk);
      chan = ~c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    ec  = sc ? (scanY ? 3'b001 : 3'b101) : c;
    ese = sc ? 1'b0 : se;
    if (sc) scanY = !scanY;
    check(rises == 24, "R1 rising edges per frame", rises, 24);
    check(cmdRx == expCmd(ec, m, ese, pd), "R2 command word", cmdRx, expCmd(ec, m, ese, pd));
    if (m) check(result == expRes(v, m), "R6 narrow result", result, expRes(v, m));
    else   check(result == expRes(v, m), "R5 wide result", result, expRes(v, m));
    check(resultChan == ec, "R8 result channel", resultChan, ec);
    check(busy, "R4 busy during done", busy, 1);
    check(lastHi == dv + 1 && lastLo == dv + 1, "R10 half period", lastHi, dv + 1);
    @(negedge clk);
    check(!done, "R4 done single cycle", done, 0);
    check(result == expRes(v, m), "R4 result held", result, expRes(v, m));
    check(csN && !dclk, "R1 idle after frame", {csN, dclk}, 2);
  endtask

  initial begin
    void'($urandom(32'd4611));
    repeat (3) @(negedge clk);
    check(!busy && !done && csN && !dclk && !din && result == 0 && resultChan == 0,
          "R11 reset state", {busy, done, csN, dclk, din}, 5'b00100);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    frame(3'b011, 1'b0, 1'b1, 2'b11, 1'b0, 8'd0, 12'hFFF, 1'b0);
    frame(3'b110, 1'b1, 1'b0, 2'b00, 1'b0, 8'd1, 12'hFFF, 1'b0);
    frame(3'b000, 1'b0, 1'b0, 2'b01, 1'b0, 8'd2, 12'h000, 1'b0);
    frame(3'b111, 1'b0, 1'b1, 2'b10, 1'b0, 8'd0, 12'h001, 1'b0);
    frame(3'b100, 1'b1, 1'b1, 2'b10, 1'b0, 8'd0, 12'h810, 1'b0);
    frame(3'b010, 1'b0, 1'b0, 2'b00, 1'b0, 8'd3, 12'h800, 1'b0);
    // R7: back-to-back request with start held, gap measured at next frame
    start = 1'b1;
    frame(3'b001, 1'b0, 1'b1, 2'b00, 1'b0, 8'd3, 12'h5A5, 1'b0);
    check(lastGap >= 2 * 4, "R7 deselect gap", lastGap, 8);
    // R8: scan alternation
    for (int i = 0; i < 4; i++)
      frame(3'b110, i[0], 1'b1, 2'b00, 1'b1, 8'd1, 12'(i * 12'h3C7), 1'b0);
    // R9: start while busy ignored
    frame(3'b011, 1'b0, 1'b1, 2'b01, 1'b0, 8'd1, 12'hA5C, 1'b1);
    repeat (40) @(negedge clk);
    check(!busy && csN, "R9 no extra frame", {busy, csN}, 1);
    // random
    for (int i = 0; i < 30; i++) begin
      frame(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0),
            8'($urandom_range(0, 3)), 12'($urandom_range(0, 4095)), 1'b0);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule